// File: doc/BRIEF.md
# Divider Configuration Loader

This block keeps the settings a clock synthesizer needs: a 9-bit feedback divide value, a 2-bit output-divide code and a 2-bit test code. The settings can come from a set of static parallel pins or from a three-wire serial port. While the active-low parallel strobe is low, the active registers follow the parallel pins. The rising edge of the strobe freezes them. While the strobe is high, the serial port owns the registers. Bits shift in on each rising edge of the serial clock. The serial load line then passes the frame to the active registers, or stays high so that every clock edge passes the frame straight through.

All external pins are asynchronous to the system clock. They pass through two-flop synchronisers, and edges are found by comparing each synchronised level with its value one cycle earlier. A mode flag tells the divider logic whether the last update came from the serial port. A master-reset request is carried through to the dividers. It never touches the stored settings.

Top module: `divcfg_loader`

## Requirements
- R1: During and after the asynchronous reset, for SYNC_STAGES+1 system cycles after release, the active registers take the synchronised parallel pins. The test code is 00 and the serial-mode flag is 0.
- R2: While the parallel strobe `pload_n` is low, `m_out` and `n_out` follow `m_pin` and `n_pin`, each pin change appearing within 3 system cycles.
- R3: On the rising edge of `pload_n`, the last pin values are held. Later changes of `m_pin` and `n_pin` do not reach the outputs while the strobe stays high and no serial update occurs.
- R4: With `pload_n` high, each rising `sclk` shifts `sdata` into a 14-bit frame. The first bit sent is T1, then T0, a null bit, N1, N0 and M8 down to M0. A rising `sload` copies the frame to `t_out`, `n_out` and `m_out`.
- R5: The value of the null bit has no effect on any output.
- R6: After `sload` falls, the loaded values are held. Further `sclk` shifting with `sload` low does not change the outputs.
- R7: While `sload` is high, every rising `sclk` updates the outputs from the shift register, including the newly shifted bit. The outputs then match the last 14 bits sent, using the R4 field positions.
- R8: `serial_mode` goes to 1 on any serial update and returns to 0 while `pload_n` is low.
- R9: `t_out` shows the loaded test code while `serial_mode` is 1 and is forced to 00 in parallel mode.
- R10: `div_rst` follows `mreset` after synchronisation. Asserting `mreset` leaves `m_out`, `n_out`, `t_out` and `serial_mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreset | input | 1 | Master reset request for the dividers |
| pload_n | input | 1 | Active-low parallel load strobe |
| m_pin | input | 9 | Parallel feedback divide value |
| n_pin | input | 2 | Parallel output-divide code |
| sclk | input | 1 | Serial clock |
| sdata | input | 1 | Serial data |
| sload | input | 1 | Serial load |
| m_out | output | 9 | Active feedback divide value |
| n_out | output | 2 | Active output-divide code |
| t_out | output | 2 | Active test code (00 in parallel mode) |
| serial_mode | output | 1 | Last update came from the serial port |
| div_rst | output | 1 | Synchronised divider reset request |

## Verification
The properties assume that every pin level is held for several system cycles. This means each synchroniser edge is seen once and the data pins settle before the strobe that samples them. They also assume that a rising serial clock never arrives in the same synchronised cycle as a serial-load edge. The bench keeps within these limits by holding every level for at least four system clocks. It changes serial data only while the serial clock is low and changes parallel pins only away from strobe edges.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int FRAME_W = T_W + 1 + N_W + M_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  // frame layout, MSB first on the wire: t, null, n, m
  function automatic cfg_t frame_to_cfg(input logic [FRAME_W-1:0] f);
    cfg_t c;
    c.t = f[FRAME_W-1 -: T_W];
    c.n = f[M_W +: N_W];
    c.m = f[M_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stg
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = d;
      end else begin : g_next
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/divcfg_shreg.sv
module divcfg_shreg
  import divcfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pl_s,
  input  logic sc_s,
  input  logic sd_s,
  output logic sc_rise,
  output cfg_t sr_cfg,
  output cfg_t sh_cfg
);
  logic               sc_d;
  logic [FRAME_W-1:0] sr_q, sr_d, sr_shift;
  logic               shift_en;

  assign sc_rise  = sc_s & ~sc_d;
  assign shift_en = pl_s & sc_rise;
  assign sr_shift = {sr_q[FRAME_W-2:0], sd_s};

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = sr_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      sc_d <= 1'b0;
    end else begin
      sr_q <= sr_d;
      sc_d <= sc_s;
    end
  end

  assign sr_cfg = frame_to_cfg(sr_q);
  assign sh_cfg = frame_to_cfg(sr_shift);
endmodule

// File: rtl/divcfg_active.sv
module divcfg_active
  import divcfg_pkg::*;
#(
  parameter int BOOT_CYC = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pl_s,
  input  logic           sl_s,
  input  logic           sc_rise,
  input  logic [M_W-1:0] m_s,
  input  logic [N_W-1:0] n_s,
  input  cfg_t           sr_cfg,
  input  cfg_t           sh_cfg,
  output cfg_t           cur,
  output logic           ser_q,
  output logic           boot_done
);
  localparam int CNT_W = $clog2(BOOT_CYC + 1);

  logic [CNT_W-1:0] boot_q, boot_d;
  logic             sl_d, sl_rise;
  cfg_t             cur_d;
  logic             ser_d;

  assign boot_done = (boot_q == CNT_W'(BOOT_CYC));
  assign sl_rise   = sl_s & ~sl_d;

  always_comb begin
    boot_d = boot_q;
    if (!boot_done) boot_d = boot_q + 1'b1;
  end

  always_comb begin
    cur_d = cur;
    ser_d = ser_q;
    if (!boot_done || !pl_s) begin
      cur_d.m = m_s;
      cur_d.n = n_s;
      ser_d   = 1'b0;
      if (!boot_done) cur_d.t = '0;
    end else if (sl_rise) begin
      cur_d = sr_cfg;
      ser_d = 1'b1;
    end else if (sl_s && sc_rise) begin
      cur_d = sh_cfg;
      ser_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= '0;
      sl_d   <= 1'b0;
      cur    <= '0;
      ser_q  <= 1'b0;
    end else begin
      boot_q <= boot_d;
      sl_d   <= sl_s;
      cur    <= cur_d;
      ser_q  <= ser_d;
    end
  end
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mreset,
  input  logic           pload_n,
  input  logic [M_W-1:0] m_pin,
  input  logic [N_W-1:0] n_pin,
  input  logic           sclk,
  input  logic           sdata,
  input  logic           sload,
  output logic [M_W-1:0] m_out,
  output logic [N_W-1:0] n_out,
  output logic [T_W-1:0] t_out,
  output logic           serial_mode,
  output logic           div_rst
);
  localparam int IN_W     = M_W + N_W + 5;
  localparam int BOOT_CYC = SYNC_STAGES + 1;

  logic [IN_W-1:0] raw, syn;
  logic            mr_s, pl_s, sl_s, sc_s, sd_s;
  logic [M_W-1:0]  m_s;
  logic [N_W-1:0]  n_s;
  logic            sc_rise, boot_done, ser_q;
  cfg_t            sr_cfg, sh_cfg, cur;

  assign raw = {mreset, pload_n, sload, sclk, sdata, n_pin, m_pin};

  divcfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign {mr_s, pl_s, sl_s, sc_s, sd_s, n_s, m_s} = syn;

  divcfg_shreg u_shreg (
    .clk(clk), .rst_n(rst_n), .pl_s(pl_s), .sc_s(sc_s), .sd_s(sd_s),
    .sc_rise(sc_rise), .sr_cfg(sr_cfg), .sh_cfg(sh_cfg)
  );

  divcfg_active #(.BOOT_CYC(BOOT_CYC)) u_active (
    .clk(clk), .rst_n(rst_n), .pl_s(pl_s), .sl_s(sl_s), .sc_rise(sc_rise),
    .m_s(m_s), .n_s(n_s), .sr_cfg(sr_cfg), .sh_cfg(sh_cfg),
    .cur(cur), .ser_q(ser_q), .boot_done(boot_done)
  );

  assign m_out       = cur.m;
  assign n_out       = cur.n;
  assign t_out       = ser_q ? cur.t : '0;
  assign serial_mode = ser_q;
  assign div_rst     = mr_s;
endmodule

// File: rtl/divcfg_loader_chk.sv
module divcfg_loader_chk
  import divcfg_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           boot_done,
  input logic           pl_s,
  input logic           sl_s,
  input logic           sc_s,
  input logic [M_W-1:0] m_s,
  input logic [N_W-1:0] n_s,
  input cfg_t           sr_cfg,
  input logic [M_W-1:0] m_out,
  input logic [N_W-1:0] n_out,
  input logic [T_W-1:0] t_out,
  input logic           serial_mode
);
  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && !pl_s) |=> (m_out == $past(m_s) && n_out == $past(n_s))); // R2

  AST_PAR_TEST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pl_s) |=> (t_out == '0 && !serial_mode)); // R9

  AST_SLOAD_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && pl_s && sl_s && !$past(sl_s))
      |=> ({t_out, n_out, m_out} == $past(sr_cfg) && serial_mode)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && pl_s && !(sl_s && !$past(sl_s)) && !(sl_s && sc_s && !$past(sc_s)))
      |=> ($stable(m_out) && $stable(n_out) && $stable(t_out) && $stable(serial_mode))); // R6

  AST_BOOT_TEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_done) |=> (t_out == '0)); // R1
endmodule

bind divcfg_loader divcfg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .boot_done(boot_done), .pl_s(pl_s), .sl_s(sl_s),
  .sc_s(sc_s), .m_s(m_s), .n_s(n_s), .sr_cfg(sr_cfg), .m_out(m_out),
  .n_out(n_out), .t_out(t_out), .serial_mode(serial_mode)
);

// File: tb/divcfg_loader_bench.sv
`timescale 1ns/1ps
module divcfg_loader_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mreset, pload_n, sclk, sdata, sload;
  logic [8:0] m_pin;
  logic [1:0] n_pin;
  logic [8:0] m_out;
  logic [1:0] n_out, t_out;
  logic       serial_mode, div_rst;

  int n_chk = 0;
  int n_bad = 0;
  logic [13:0] sr_model = '0;

  always #10 clk = ~clk;

  divcfg_loader u_divcfg_loader (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .pload_n(pload_n),
    .m_pin(m_pin), .n_pin(n_pin), .sclk(sclk), .sdata(sdata), .sload(sload),
    .m_out(m_out), .n_out(n_out), .t_out(t_out),
    .serial_mode(serial_mode), .div_rst(div_rst)
  );

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(input logic [1:0] t, input logic nb,
                                     input logic [1:0] n, input logic [8:0] m);
    return {t, nb, n, m};
  endfunction

  task automatic send_bit(input logic b);
    sdata = b;
    settle(4);
    sclk = 1'b1;
    settle(4);
    sclk = 1'b0;
    settle(4);
    sr_model = {sr_model[12:0], b};
  endtask

  task automatic send_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic chk_frame(input string tag, input logic [13:0] f);
    chk({tag, " m"}, 32'(m_out), 32'(f[8:0]));
    chk({tag, " n"}, 32'(n_out), 32'(f[10:9]));
    chk({tag, " t"}, 32'(t_out), 32'(f[13:12]));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; mreset = 1'b0; pload_n = 1'b1; sclk = 1'b0; sdata = 1'b0;
    sload = 1'b0; m_pin = 9'h15A; n_pin = 2'b10;
    settle(3);
    chk("R1 m in reset", 32'(m_out), 32'h0);
    rst_n = 1'b1;
    settle(6);
    chk("R1 m after reset", 32'(m_out), 32'h15A);
    chk("R1 n after reset", 32'(n_out), 32'h2);
    chk("R1 t after reset", 32'(t_out), 32'h0);
    chk("R1 serial_mode", 32'(serial_mode), 32'h0);
  endtask

  task automatic t_par_transparent;
    pload_n = 1'b0;
    m_pin = 9'h0C3; n_pin = 2'b01;
    settle(4);
    chk("R2 m follow1", 32'(m_out), 32'h0C3);
    chk("R2 n follow1", 32'(n_out), 32'h1);
    m_pin = 9'h1FF; n_pin = 2'b11;
    settle(4);
    chk("R2 m follow2", 32'(m_out), 32'h1FF);
    chk("R2 n follow2", 32'(n_out), 32'h3);
  endtask

  task automatic t_par_capture;
    m_pin = 9'h019; n_pin = 2'b00;
    settle(4);
    pload_n = 1'b1;
    settle(4);
    m_pin = 9'h0AA; n_pin = 2'b11;
    settle(6);
    chk("R3 m held", 32'(m_out), 32'h019);
    chk("R3 n held", 32'(n_out), 32'h0);
    chk("R9 t parallel", 32'(t_out), 32'h0);
  endtask

  task automatic t_serial_frame;
    logic [13:0] f;
    f = mk(2'b10, 1'b0, 2'b01, 9'h11C);
    send_frame(f);
    chk("R6 no load before sload", 32'(m_out), 32'h019);
    sload = 1'b1;
    settle(5);
    chk_frame("R4 R9 frame", f);
    chk("R8 serial set", 32'(serial_mode), 32'h1);
    sload = 1'b0;
    settle(5);
    chk_frame("R6 after fall", f);
    send_frame(mk(2'b01, 1'b1, 2'b10, 9'h0F0));
    chk_frame("R6 shift ignored", f);
  endtask

  task automatic t_null_ignored;
    logic [13:0] f0, f1;
    f0 = mk(2'b11, 1'b0, 2'b11, 9'h155);
    f1 = mk(2'b11, 1'b1, 2'b11, 9'h155);
    send_frame(f1);
    sload = 1'b1; settle(5); sload = 1'b0; settle(5);
    chk_frame("R5 null=1", f0);
    send_frame(mk(2'b00, 1'b1, 2'b00, 9'h000));
    send_frame(f0);
    sload = 1'b1; settle(5); sload = 1'b0; settle(5);
    chk_frame("R5 null=0", f0);
  endtask

  task automatic t_sload_high;
    send_frame(mk(2'b01, 1'b0, 2'b10, 9'h0E7));
    sload = 1'b1;
    settle(5);
    chk_frame("R7 entry", sr_model);
    for (int i = 0; i < 3; i++) begin
      send_bit(i[0]);
      chk_frame("R7 per clock", sr_model);
    end
    sload = 1'b0;
    settle(5);
    chk_frame("R7 latched", sr_model);
  endtask

  task automatic t_mreset;
    logic [8:0] m0; logic [1:0] n0, t0;
    m0 = m_out; n0 = n_out; t0 = t_out;
    mreset = 1'b1;
    settle(5);
    chk("R10 div_rst high", 32'(div_rst), 32'h1);
    chk("R10 m kept", 32'(m_out), 32'(m0));
    chk("R10 n kept", 32'(n_out), 32'(n0));
    chk("R10 t kept", 32'(t_out), 32'(t0));
    chk("R10 mode kept", 32'(serial_mode), 32'h1);
    mreset = 1'b0;
    settle(5);
    chk("R10 div_rst low", 32'(div_rst), 32'h0);
  endtask

  task automatic t_mode_clear;
    m_pin = 9'h077; n_pin = 2'b01;
    settle(2);
    pload_n = 1'b0;
    settle(5);
    chk("R8 serial cleared", 32'(serial_mode), 32'h0);
    chk("R9 t forced low", 32'(t_out), 32'h0);
    chk("R2 m from pins", 32'(m_out), 32'h077);
    pload_n = 1'b1;
    settle(5);
    chk("R8 stays clear", 32'(serial_mode), 32'h0);
    chk("R9 t stays low", 32'(t_out), 32'h0);
  endtask

  initial begin
    t_reset();
    t_par_transparent();
    t_par_capture();
    t_serial_frame();
    t_null_ignored();
    t_sload_high();
    t_mreset();
    t_mode_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule